// File: doc/BRIEF.md
# In-Order Completion Queue Controller

This block keeps a record of every instruction that has left dispatch, in program order, and lets each one write its result to the architectural registers only when it is the oldest unfinished piece of work. The dispatcher offers up to two instructions per cycle, each with a two-bit class, and receives a queue tag and an "issue to unit" flag for each accepted slot. Execution units later report completion against the tag. The controller drives a commit strobe for up to two of the oldest finished instructions per cycle and frees their entries.

A branch that writes neither the count nor the link register is accepted without taking an entry and is never issued. A branch that writes one of those registers takes an entry but is not sent to a unit, so it is recorded as finished at allocation. An entry finished with an exception stops commit at the head and raises a trap output. A flush input discards all work younger than a named tag, with an option to discard that tag as well, in one cycle, so that recovery after a wrong branch guess or a fault starts from a clean, in-order state.

Top module: `cq_ctrl`

## Requirements
- R1: After reset the queue is empty: commit_valid is 0, trap_valid is 0, the lane-0 tag offered is 0, and with both slots valid and of class 0 both slots are ready.
- R2: Tags are handed out consecutively modulo 6 starting at the tail; lane 1 takes the tag after lane 0 when lane 0 takes an entry. A slot that needs an entry is ready only if a free entry remains for it after the older slot; lane 1 is accepted only together with lane 0; with 6 entries held, a slot needing an entry is not ready.
- R3: Class 2 (branch writing no count or link register) is accepted even when the queue is full, raises no disp_issue bit and consumes no tag or entry.
- R4: Class 3 (branch writing count or link) takes an entry and a tag, raises no disp_issue bit, and becomes committable in the cycle after it is accepted without any finish report.
- R5: Classes 0 (integer) and 1 (floating point) raise disp_issue when accepted; their entry commits only after a finish report, and the commit strobe appears in the cycle after that report.
- R6: Commit is in program order: a finished entry never commits while an older entry is unfinished.
- R7: Up to two entries commit per cycle; commit_valid bit 1 is set only with bit 0, lane 0 carries the head tag and lane 1 the next tag, each with its destination.
- R8: A finish report with fin_exc set marks the entry faulty; when it is the head, trap_valid is high with trap_tag equal to its tag and nothing commits, for as long as it stays the head.
- R9: A flush with flush_self low removes every entry younger than flush_tag and the next tag handed out is flush_tag+1; with flush_self high flush_tag is removed too and the next tag is flush_tag. Removed entries never commit, even if they had finished.
- R10: In a flush cycle no slot is ready and nothing commits; commit of surviving finished entries resumes in the next cycle.
- R11: Entries freed by commit are reused: after commits the queue accepts new work again and tags wrap from 5 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 2 | Dispatch request per slot, bit 0 is the older |
| disp_class | input | 4 | Class per slot, 2 bits each (0 int, 1 fp, 2 plain branch, 3 count/link branch) |
| disp_dest | input | 10 | Destination register id per slot, 5 bits each |
| disp_ready | output | 2 | Slot can be accepted this cycle |
| disp_tag | output | 6 | Queue tag assigned per slot, 3 bits each |
| disp_issue | output | 2 | Accepted slot goes to an execution unit |
| fin_valid | input | 2 | Finish report per reporting port |
| fin_tag | input | 6 | Tag of finished instruction, 3 bits per port |
| fin_exc | input | 2 | Finished instruction raised an exception |
| flush_valid | input | 1 | Discard younger work this cycle |
| flush_self | input | 1 | Discard flush_tag itself as well |
| flush_tag | input | 3 | Youngest surviving (or first discarded) tag |
| commit_valid | output | 2 | Commit strobe per lane, lane 0 is the head |
| commit_tag | output | 6 | Tag committed per lane, 3 bits each |
| commit_dest | output | 10 | Destination committed per lane, 5 bits each |
| trap_valid | output | 1 | Head entry is finished with an exception |
| trap_tag | output | 3 | Tag of the faulting head entry |

## Verification
A stale or miscounted occupancy shows at the ports as a wrong disp_ready or a wrong next tag in the very next cycle, so the bench reads disp_tag and disp_ready after every fill, commit and flush. A lost or misplaced finish bit shows as a commit strobe one cycle early, one cycle late, or out of order, and a killed entry that survives a flush shows up later as an extra commit; each of these is watched cycle by cycle after the triggering stimulus.

// File: rtl/cq_pkg.sv
package cq_pkg;

  typedef enum logic [1:0] {
    CL_INT      = 2'd0,
    CL_FP       = 2'd1,
    CL_BR_PLAIN = 2'd2,
    CL_BR_REG   = 2'd3
  } iclass_e;

  // position d steps after p on a ring of the given size
  function automatic int unsigned ring_add(int unsigned p, int unsigned d, int unsigned size);
    return (p + d) % size;
  endfunction

  // distance of tag behind the head on the ring (0 = oldest)
  function automatic int unsigned ring_age(int unsigned tag, int unsigned head, int unsigned size);
    return (tag + size - head) % size;
  endfunction

  function automatic logic needs_entry(logic [1:0] cls);
    return cls != CL_BR_PLAIN;
  endfunction

  function automatic logic goes_to_unit(logic [1:0] cls);
    return (cls == CL_INT) || (cls == CL_FP);
  endfunction

  function automatic logic done_at_alloc(logic [1:0] cls);
    return cls == CL_BR_REG;
  endfunction

endpackage

// File: rtl/cq_alloc.sv
module cq_alloc
  import cq_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int NDISP = 2,
  parameter int TAG_W = 3,
  parameter int CNT_W = 3
) (
  input  logic [NDISP-1:0]            disp_valid,
  input  logic [NDISP-1:0][1:0]       disp_class,
  input  logic [CNT_W-1:0]            count,
  input  logic [TAG_W-1:0]            tail,
  input  logic                        flush_valid,
  output logic [NDISP-1:0]            disp_ready,
  output logic [NDISP-1:0]            disp_issue,
  output logic [NDISP-1:0]            alloc_en,
  output logic [NDISP-1:0]            alloc_fin,
  output logic [NDISP-1:0][TAG_W-1:0] slot_tag,
  output logic [CNT_W-1:0]            n_alloc
);

  logic [NDISP-1:0] need;
  logic [NDISP-1:0] take;

  always_comb begin
    for (int s = 0; s < NDISP; s++) begin
      need[s]      = needs_entry(disp_class[s]);
      alloc_fin[s] = done_at_alloc(disp_class[s]);
    end
  end

  always_comb begin
    int unsigned used;
    int unsigned free_n;
    logic        chain;
    used   = 0;
    chain  = 1'b1;
    free_n = DEPTH - 32'(count);
    for (int s = 0; s < NDISP; s++) begin
      disp_ready[s] = chain && !flush_valid && ((used + 32'(need[s])) <= free_n);
      slot_tag[s]   = TAG_W'(ring_add(32'(tail), used, DEPTH));
      take[s]       = disp_valid[s] && disp_ready[s];
      alloc_en[s]   = take[s] && need[s];
      disp_issue[s] = take[s] && goes_to_unit(disp_class[s]);
      if (take[s]) used = used + 32'(need[s]);
      chain = chain && take[s];
    end
    n_alloc = CNT_W'(used);
  end

endmodule

// File: rtl/cq_entries.sv
module cq_entries
  import cq_pkg::*;
#(
  parameter int DEPTH  = 6,
  parameter int NDISP  = 2,
  parameter int NFIN   = 2,
  parameter int NRET   = 2,
  parameter int TAG_W  = 3,
  parameter int DEST_W = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NDISP-1:0]             alloc_en,
  input  logic [NDISP-1:0]             alloc_fin,
  input  logic [NDISP-1:0][TAG_W-1:0]  slot_tag,
  input  logic [NDISP-1:0][DEST_W-1:0] slot_dest,
  input  logic [NFIN-1:0]              fin_valid,
  input  logic [NFIN-1:0][TAG_W-1:0]   fin_tag,
  input  logic [NFIN-1:0]              fin_exc,
  input  logic [NRET-1:0]              ret_en,
  input  logic [TAG_W-1:0]             head,
  input  logic                         flush_valid,
  input  logic                         flush_self,
  input  logic [TAG_W-1:0]             flush_tag,
  output logic [DEPTH-1:0]             ent_valid,
  output logic [DEPTH-1:0]             ent_fin,
  output logic [DEPTH-1:0]             ent_exc,
  output logic [DEPTH-1:0][DEST_W-1:0] ent_dest
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic              v_q, f_q, x_q;
    logic [DEST_W-1:0] d_q;
    logic              kill, ret_hit, alloc_hit, a_fin, fin_hit, fin_x;
    logic [DEST_W-1:0] a_dest;

    always_comb begin
      kill = flush_valid &&
             ((ring_age(32'(i), 32'(head), DEPTH) > ring_age(32'(flush_tag), 32'(head), DEPTH)) ||
              (flush_self && (flush_tag == TAG_W'(i))));
      ret_hit = 1'b0;
      for (int r = 0; r < NRET; r++)
        if (ret_en[r] && (TAG_W'(ring_add(32'(head), r, DEPTH)) == TAG_W'(i))) ret_hit = 1'b1;
      alloc_hit = 1'b0;
      a_fin     = 1'b0;
      a_dest    = '0;
      for (int s = 0; s < NDISP; s++)
        if (alloc_en[s] && (slot_tag[s] == TAG_W'(i))) begin
          alloc_hit = 1'b1;
          a_fin     = alloc_fin[s];
          a_dest    = slot_dest[s];
        end
      fin_hit = 1'b0;
      fin_x   = 1'b0;
      for (int f = 0; f < NFIN; f++)
        if (fin_valid[f] && (fin_tag[f] == TAG_W'(i))) begin
          fin_hit = 1'b1;
          fin_x   = fin_x | fin_exc[f];
        end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        f_q <= 1'b0;
        x_q <= 1'b0;
        d_q <= '0;
      end else if (kill || ret_hit) begin
        v_q <= 1'b0;
        f_q <= 1'b0;
        x_q <= 1'b0;
      end else if (alloc_hit) begin
        v_q <= 1'b1;
        f_q <= a_fin;
        x_q <= 1'b0;
        d_q <= a_dest;
      end else if (fin_hit && v_q) begin
        f_q <= 1'b1;
        x_q <= fin_x;
      end
    end

    assign ent_valid[i] = v_q;
    assign ent_fin[i]   = f_q;
    assign ent_exc[i]   = x_q;
    assign ent_dest[i]  = d_q;

    AST_ALLOC_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_hit |-> !v_q);  // R2
    AST_RETIRE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      ret_hit |-> (v_q && f_q && !x_q));  // R6
  end

endmodule

// File: rtl/cq_retire.sv
module cq_retire
  import cq_pkg::*;
#(
  parameter int DEPTH  = 6,
  parameter int NRET   = 2,
  parameter int TAG_W  = 3,
  parameter int CNT_W  = 3,
  parameter int DEST_W = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [TAG_W-1:0]             head,
  input  logic [CNT_W-1:0]             count,
  input  logic [DEPTH-1:0]             ent_valid,
  input  logic [DEPTH-1:0]             ent_fin,
  input  logic [DEPTH-1:0]             ent_exc,
  input  logic [DEPTH-1:0][DEST_W-1:0] ent_dest,
  input  logic                         flush_valid,
  output logic [NRET-1:0]              ret_en,
  output logic [NRET-1:0][TAG_W-1:0]   ret_tag,
  output logic [NRET-1:0][DEST_W-1:0]  ret_dest,
  output logic [CNT_W-1:0]             n_ret,
  output logic                         trap_valid,
  output logic [TAG_W-1:0]             trap_tag
);

  always_comb begin
    logic        chain;
    int unsigned n;
    chain = 1'b1;
    n     = 0;
    for (int r = 0; r < NRET; r++) begin
      ret_tag[r]  = TAG_W'(ring_add(32'(head), r, DEPTH));
      ret_dest[r] = ent_dest[ret_tag[r]];
      chain = chain && (r < 32'(count)) && ent_fin[ret_tag[r]] &&
              !ent_exc[ret_tag[r]] && !flush_valid;
      ret_en[r] = chain;
      if (chain) n = n + 1;
    end
    n_ret = CNT_W'(n);
  end

  assign trap_valid = (count != '0) && ent_fin[head] && ent_exc[head];
  assign trap_tag   = head;

  for (genvar r = 1; r < NRET; r++) begin : g_lane_chk
    AST_LANE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      ret_en[r] |-> ret_en[r-1]);  // R7
  end

  AST_TRAP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> !ret_en[0]);  // R8
  AST_HEAD_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ret_en[0] |-> ent_valid[head]);  // R6

endmodule

// File: rtl/cq_ctrl.sv
module cq_ctrl
  import cq_pkg::*;
#(
  parameter int DEPTH  = 6,
  parameter int NDISP  = 2,
  parameter int NFIN   = 2,
  parameter int NRET   = 2,
  parameter int DEST_W = 5,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NDISP-1:0]         disp_valid,
  input  logic [NDISP*2-1:0]       disp_class,
  input  logic [NDISP*DEST_W-1:0]  disp_dest,
  output logic [NDISP-1:0]         disp_ready,
  output logic [NDISP*TAG_W-1:0]   disp_tag,
  output logic [NDISP-1:0]         disp_issue,
  input  logic [NFIN-1:0]          fin_valid,
  input  logic [NFIN*TAG_W-1:0]    fin_tag,
  input  logic [NFIN-1:0]          fin_exc,
  input  logic                     flush_valid,
  input  logic                     flush_self,
  input  logic [TAG_W-1:0]         flush_tag,
  output logic [NRET-1:0]          commit_valid,
  output logic [NRET*TAG_W-1:0]    commit_tag,
  output logic [NRET*DEST_W-1:0]   commit_dest,
  output logic                     trap_valid,
  output logic [TAG_W-1:0]         trap_tag
);

  logic [TAG_W-1:0]             head_q, tail_q;
  logic [CNT_W-1:0]             count_q;
  logic [NDISP-1:0]             alloc_en, alloc_fin;
  logic [NDISP-1:0][TAG_W-1:0]  slot_tag;
  logic [CNT_W-1:0]             n_alloc, n_ret;
  logic [NRET-1:0]              ret_en;
  logic [NRET-1:0][TAG_W-1:0]   ret_tag;
  logic [NRET-1:0][DEST_W-1:0]  ret_dest;
  logic [DEPTH-1:0]             ent_valid, ent_fin, ent_exc;
  logic [DEPTH-1:0][DEST_W-1:0] ent_dest;
  logic [TAG_W-1:0]             head_d, tail_d;
  logic [CNT_W-1:0]             count_d;

  cq_alloc #(.DEPTH(DEPTH), .NDISP(NDISP), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_alloc (
    .disp_valid (disp_valid),
    .disp_class (disp_class),
    .count      (count_q),
    .tail       (tail_q),
    .flush_valid(flush_valid),
    .disp_ready (disp_ready),
    .disp_issue (disp_issue),
    .alloc_en   (alloc_en),
    .alloc_fin  (alloc_fin),
    .slot_tag   (slot_tag),
    .n_alloc    (n_alloc)
  );

  cq_entries #(.DEPTH(DEPTH), .NDISP(NDISP), .NFIN(NFIN), .NRET(NRET),
               .TAG_W(TAG_W), .DEST_W(DEST_W)) u_entries (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_en   (alloc_en),
    .alloc_fin  (alloc_fin),
    .slot_tag   (slot_tag),
    .slot_dest  (disp_dest),
    .fin_valid  (fin_valid),
    .fin_tag    (fin_tag),
    .fin_exc    (fin_exc),
    .ret_en     (ret_en),
    .head       (head_q),
    .flush_valid(flush_valid),
    .flush_self (flush_self),
    .flush_tag  (flush_tag),
    .ent_valid  (ent_valid),
    .ent_fin    (ent_fin),
    .ent_exc    (ent_exc),
    .ent_dest   (ent_dest)
  );

  cq_retire #(.DEPTH(DEPTH), .NRET(NRET), .TAG_W(TAG_W), .CNT_W(CNT_W),
              .DEST_W(DEST_W)) u_retire (
    .clk        (clk),
    .rst_n      (rst_n),
    .head       (head_q),
    .count      (count_q),
    .ent_valid  (ent_valid),
    .ent_fin    (ent_fin),
    .ent_exc    (ent_exc),
    .ent_dest   (ent_dest),
    .flush_valid(flush_valid),
    .ret_en     (ret_en),
    .ret_tag    (ret_tag),
    .ret_dest   (ret_dest),
    .n_ret      (n_ret),
    .trap_valid (trap_valid),
    .trap_tag   (trap_tag)
  );

  assign disp_tag     = slot_tag;
  assign commit_valid = ret_en;
  assign commit_tag   = ret_tag;
  assign commit_dest  = ret_dest;

  always_comb begin
    int unsigned keep;
    keep = ring_age(32'(flush_tag), 32'(head_q), DEPTH);
    if (flush_valid) begin
      head_d  = head_q;
      tail_d  = flush_self ? flush_tag : TAG_W'(ring_add(32'(flush_tag), 1, DEPTH));
      count_d = CNT_W'(flush_self ? keep : keep + 1);
    end else begin
      head_d  = TAG_W'(ring_add(32'(head_q), 32'(n_ret), DEPTH));
      tail_d  = TAG_W'(ring_add(32'(tail_q), 32'(n_alloc), DEPTH));
      count_d = count_q + n_alloc - n_ret;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      head_q  <= head_d;
      tail_q  <= tail_d;
      count_q <= count_d;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    32'(count_q) <= DEPTH);  // R2
  AST_OCCUPANCY: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ent_valid) == 32'(count_q));  // R11
  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> (disp_ready == '0) && (commit_valid == '0));  // R10
  AST_FLUSH_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> (count_q <= $past(count_q)));  // R9

endmodule

// File: tb/cq_ctrl_bench.sv
module cq_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] disp_valid;
  logic [3:0] disp_class;
  logic [9:0] disp_dest;
  logic [1:0] disp_ready;
  logic [5:0] disp_tag;
  logic [1:0] disp_issue;
  logic [1:0] fin_valid;
  logic [5:0] fin_tag;
  logic [1:0] fin_exc;
  logic       flush_valid;
  logic       flush_self;
  logic [2:0] flush_tag;
  logic [1:0] commit_valid;
  logic [5:0] commit_tag;
  logic [9:0] commit_dest;
  logic       trap_valid;
  logic [2:0] trap_tag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  cq_ctrl u_cq_ctrl (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_class(disp_class), .disp_dest(disp_dest),
    .disp_ready(disp_ready), .disp_tag(disp_tag), .disp_issue(disp_issue),
    .fin_valid(fin_valid), .fin_tag(fin_tag), .fin_exc(fin_exc),
    .flush_valid(flush_valid), .flush_self(flush_self), .flush_tag(flush_tag),
    .commit_valid(commit_valid), .commit_tag(commit_tag), .commit_dest(commit_dest),
    .trap_valid(trap_valid), .trap_tag(trap_tag)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    disp_valid = 2'b00; disp_class = 4'h0; disp_dest = '0;
    fin_valid = 2'b00; fin_tag = '0; fin_exc = 2'b00;
    flush_valid = 1'b0; flush_self = 1'b0; flush_tag = '0;
  endtask

  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    disp_valid = 2'b11; disp_class = 4'h0;
    settle();
    chk("R1 ready", disp_ready, 2'b11);
    chk("R1 tag0", disp_tag[2:0], 0);
    chk("R1 commit", commit_valid, 0);
    chk("R1 trap", trap_valid, 0);
    disp_valid = 2'b00;
  endtask

  task automatic t_fill();
    do_reset();
    disp_valid = 2'b11; disp_class = {2'd0, 2'd0}; disp_dest = {5'd2, 5'd1};
    settle();
    chk("R2 tags 0/1", disp_tag, {3'd1, 3'd0});
    chk("R5 issue", disp_issue, 2'b11);
    tick();
    disp_valid = 2'b11; disp_class = {2'd0, 2'd1}; disp_dest = {5'd4, 5'd3};
    settle();
    chk("R2 tags 2/3", disp_tag, {3'd3, 3'd2});
    tick();
    disp_valid = 2'b01; disp_class = 4'h0;
    settle();
    chk("R2 tag 4", disp_tag[2:0], 4);
    tick();
    disp_valid = 2'b11; disp_class = 4'h0;
    settle();
    chk("R2 one free", disp_ready, 2'b01);
    chk("R2 tag 5", disp_tag[2:0], 5);
    tick();
    disp_valid = 2'b01; disp_class = 4'h0;
    settle();
    chk("R2 full stall", disp_ready[0], 0);
    disp_class = {2'd0, 2'd2};
    fin_valid = 2'b01; fin_tag = {3'd0, 3'd1};
    settle();
    chk("R3 plain branch ready when full", disp_ready[0], 1);
    chk("R3 plain branch no issue", disp_issue, 0);
    tick();
    disp_valid = 2'b01; disp_class = 4'h0;
    settle();
    chk("R6 younger finished waits", commit_valid, 0);
    chk("R3 no entry taken", disp_ready[0], 0);
    disp_valid = 2'b00;
    fin_valid = 2'b01; fin_tag = {3'd0, 3'd0};
    tick();
    settle();
    chk("R7 two commits", commit_valid, 2'b11);
    chk("R7 commit tags", commit_tag, {3'd1, 3'd0});
    chk("R7 commit dests", commit_dest, {5'd2, 5'd1});
    tick();
    disp_valid = 2'b11; disp_class = 4'h0;
    settle();
    chk("R11 ready after retire", disp_ready, 2'b11);
    chk("R11 tag wraps", disp_tag, {3'd1, 3'd0});
    chk("R6 head still unfinished", commit_valid, 0);
    disp_valid = 2'b00;
  endtask

  task automatic t_branch();
    do_reset();
    disp_valid = 2'b01; disp_class = {2'd0, 2'd3}; disp_dest = {5'd0, 5'd7};
    settle();
    chk("R4 ready", disp_ready[0], 1);
    chk("R4 no issue", disp_issue, 0);
    chk("R4 tag", disp_tag[2:0], 0);
    tick();
    settle();
    chk("R4 commit without finish", commit_valid, 2'b01);
    chk("R4 commit tag", commit_tag[2:0], 0);
    chk("R4 commit dest", commit_dest[4:0], 7);
    disp_valid = 2'b11; disp_class = {2'd1, 2'd0}; disp_dest = {5'd4, 5'd3};
    settle();
    chk("R5 issue int/fp", disp_issue, 2'b11);
    chk("R2 tags after branch", disp_tag, {3'd2, 3'd1});
    tick();
    fin_valid = 2'b01; fin_tag = {3'd0, 3'd1};
    settle();
    chk("R5 no commit before finish", commit_valid, 0);
    tick();
    settle();
    chk("R5 commit after finish", commit_valid, 2'b01);
    chk("R5 commit tag", commit_tag[2:0], 1);
    chk("R5 commit dest", commit_dest[4:0], 3);
    tick();
    settle();
    chk("R6 unfinished head", commit_valid, 0);
  endtask

  task automatic t_exc();
    do_reset();
    disp_valid = 2'b11; disp_class = 4'h0;
    tick();
    fin_valid = 2'b11; fin_tag = {3'd1, 3'd0}; fin_exc = 2'b01;
    tick();
    settle();
    chk("R8 trap", trap_valid, 1);
    chk("R8 trap tag", trap_tag, 0);
    chk("R8 no commit", commit_valid, 0);
    tick();
    settle();
    chk("R8 trap holds", trap_valid, 1);
    chk("R8 still no commit", commit_valid, 0);
    flush_valid = 1'b1; flush_self = 1'b1; flush_tag = 3'd0;
    disp_valid = 2'b01; disp_class = 4'h0;
    settle();
    chk("R10 no dispatch in flush", disp_ready, 0);
    tick();
    disp_valid = 2'b01; disp_class = 4'h0;
    settle();
    chk("R9 trap cleared", trap_valid, 0);
    chk("R9 self flush empties", commit_valid, 0);
    chk("R9 next tag self", disp_tag[2:0], 0);
    chk("R9 ready after flush", disp_ready[0], 1);
    disp_valid = 2'b00;
  endtask

  task automatic t_flush();
    do_reset();
    disp_valid = 2'b11; disp_class = 4'h0; disp_dest = {5'd11, 5'd10};
    tick();
    disp_valid = 2'b11; disp_class = 4'h0; disp_dest = {5'd13, 5'd12};
    tick();
    fin_valid = 2'b11; fin_tag = {3'd2, 3'd0};
    tick();
    flush_valid = 1'b1; flush_self = 1'b0; flush_tag = 3'd1;
    settle();
    chk("R10 no commit in flush", commit_valid, 0);
    tick();
    settle();
    chk("R10 commit resumes", commit_valid, 2'b01);
    chk("R10 commit tag", commit_tag[2:0], 0);
    chk("R10 commit dest", commit_dest[4:0], 10);
    chk("R9 next tag keep", disp_tag[2:0], 2);
    tick();
    fin_valid = 2'b01; fin_tag = {3'd0, 3'd1};
    tick();
    settle();
    chk("R9 survivor commits", commit_valid, 2'b01);
    chk("R9 survivor tag", commit_tag[2:0], 1);
    tick();
    settle();
    chk("R9 killed entry never commits", commit_valid, 0);
    chk("R9 tag reuse", disp_tag[2:0], 2);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    rst_n = 1'b0;
    idle();
    t_reset();
    t_fill();
    t_branch();
    t_exc();
    t_flush();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

endmodule